// File: doc/BRIEF.md
# Flash Bank Write-Protect Controller

This block holds the write-protect state for an on-chip flash that is split into `NUM_BANKS` banks. There are three requesters: the embedded controller, the host and the debugger. Each has its own protect bit set, stored as byte-wide registers. One configuration write can set bits in any combination of the three sets. Protect bits can only be set. Only a warm reset or a power-on reset clears them.

Each requester sends its write or erase requests through the block, tagged with a bank index. In the same cycle the block answers with a grant or a deny, using that requester's own protect set. A status encoder counts the unbroken run of protected banks, starting at bank 0, in the embedded controller's set. From that count it reports read-only-protected, fully protected, or neither. Once the flash is fully protected, every requester is denied.

A lock register holds a single bit that can only be written to one. It is modelled as a two-state machine:
- `LK_OPEN` moves to `LK_SEALED` on a lock write whose data bit 0 is 1.
- `LK_SEALED` stays there until a power-on reset.

While sealed, all writes to the protect registers are dropped.

Top module: `fwp_ctrl`

## Requirements
- R1: Bank b is protected by bit (b mod 8) of protect register b/8. Protect registers sit at `cfg_addr` 0 to NUM_REGS-1, where NUM_REGS = ceil(NUM_BANKS/8). The lock register sits at `cfg_addr` = NUM_REGS.
- R2: `cfg_sel` chooses which sets a protect-register write reaches: bit 0 the embedded controller, bit 1 the host, bit 2 the debugger. Any combination of the three is allowed, and unselected sets do not change.
- R3: A protect-register write ORs `cfg_wdata` into the selected registers. A written 0 never clears a protect bit.
- R4: When `req_vld[i]` is high, exactly one of `req_grant[i]` and `req_deny[i]` is high in the same cycle. The request is denied when requester i's bit for bank `req_bank[i]` is set. When `req_vld[i]` is low, both are low. Requester index 0 is the embedded controller, 1 the host and 2 the debugger.
- R5: A request whose bank index is NUM_BANKS or larger is denied.
- R6: Let n be the number of consecutive set bits in the embedded controller's set, counted from bank 0.
  - If n equals NUM_BANKS, `stat_all` is high.
  - Otherwise, if n equals RO_BANKS or RO_BANKS+PS_BANKS, `stat_ro` is high.
  - Otherwise both are low.
  - `stat_ro` and `stat_all` are never high together.
- R7: While `stat_all` is high, every request from every requester is denied.
- R8: Writing the lock register with data bit 0 equal to 1 sets `lock_q` from the next cycle. Other data bits and a 0 in bit 0 have no effect. Once set, `lock_q` stays high until a power-on reset.
- R9: While `lock_q` is high, protect-register writes have no effect. This includes writes that would set new bits.
- R10: A warm reset (`wrst_n` low at a clock edge) clears all protect bits and leaves `lock_q` unchanged. The power-on reset (`por_n` low, asynchronous) clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wrst_n | input | 1 | Synchronous warm reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Register address (protect registers, then lock) |
| cfg_sel | input | 3 | Target set mask: bit0 EC, bit1 host, bit2 debugger |
| cfg_wdata | input | 8 | Write data |
| req_vld | input | 3 | Write/erase request valid, one per requester |
| req_bank | input | 3 x BANK_W | Bank index per requester |
| req_grant | output | 3 | Request allowed |
| req_deny | output | 3 | Request refused (access denied) |
| stat_ro | output | 1 | Read-only region protected |
| stat_all | output | 1 | Whole flash protected |
| lock_q | output | 1 | Lock bit |

## Verification
Bad protect state shows up in the same cycle as a wrong grant or deny. The first request a requester sends after a write to the affected byte exposes it, so probing neighbouring banks and the other two requesters locates which bit or set went wrong. A bad run count shows up on `stat_ro`/`stat_all` in the cycle after the write that changed the run. The bench therefore sweeps the run through lengths RO, RO+PS, RO+PS+1 and NUM_BANKS. A lock machine stuck in the wrong state shows up at `lock_q` one cycle after the lock write, and as protect writes that take or fail to take effect.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
    localparam int NUM_REQ = 3;

    typedef enum logic [1:0] {
        REQ_EC   = 2'd0,
        REQ_HOST = 2'd1,
        REQ_DBG  = 2'd2
    } req_id_e;

    typedef enum logic [1:0] {
        ST_NONE = 2'd0,
        ST_RO   = 2'd1,
        ST_ALL  = 2'd2
    } prot_stat_e;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;
endpackage

// File: rtl/fwp_bank_regs.sv
// One requester's protect set: byte registers, set-only, cleared by either reset.
module fwp_bank_regs #(
    parameter int NUM_BANKS = 20,
    parameter int ADDR_W    = 2
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 wrst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    output logic [NUM_BANKS-1:0] prot_o
);
    localparam int NUM_REGS = (NUM_BANKS + 7) / 8;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        // last register holds only the banks that exist
        localparam int W = ((NUM_BANKS - r * 8) < 8) ? (NUM_BANKS - r * 8) : 8;
        logic [W-1:0] byte_q;

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                byte_q <= '0;
            end else if (!wrst_n) begin
                byte_q <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(r))) begin
                byte_q <= byte_q | wr_data[W-1:0];
            end
        end

        assign prot_o[r*8 +: W] = byte_q;
    end
endmodule

// File: rtl/fwp_run_status.sv
// Classifies the unbroken run of protected banks starting at bank 0.
module fwp_run_status
    import fwp_pkg::*;
#(
    parameter int NUM_BANKS = 20,
    parameter int RO_BANKS  = 4,
    parameter int PS_BANKS  = 1
) (
    input  logic [NUM_BANKS-1:0] prot_i,
    output prot_stat_e           stat_o
);
    localparam int CNT_W = $clog2(NUM_BANKS + 1);

    logic [CNT_W-1:0] run_len;
    logic             broken;

    always_comb begin
        run_len = '0;
        broken  = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (!broken && prot_i[b]) begin
                run_len = run_len + 1'b1;
            end else begin
                broken = 1'b1;
            end
        end
    end

    always_comb begin
        if (run_len == CNT_W'(NUM_BANKS)) begin
            stat_o = ST_ALL;
        end else if ((run_len == CNT_W'(RO_BANKS)) ||
                     (run_len == CNT_W'(RO_BANKS + PS_BANKS))) begin
            stat_o = ST_RO;
        end else begin
            stat_o = ST_NONE;
        end
    end
endmodule

// File: rtl/fwp_gate.sv
// Same-cycle grant/deny for one requester.
module fwp_gate #(
    parameter int NUM_BANKS = 20,
    parameter int BANK_W    = 5
) (
    input  logic                 vld_i,
    input  logic [BANK_W-1:0]    bank_i,
    input  logic [NUM_BANKS-1:0] prot_i,
    input  logic                 all_prot_i,
    output logic                 grant_o,
    output logic                 deny_o
);
    localparam int PAD_W = 1 << BANK_W;

    logic [PAD_W-1:0] prot_pad;
    logic             in_range;
    logic             hit;

    always_comb begin
        prot_pad = PAD_W'(prot_i);
        in_range = ({1'b0, bank_i} < (BANK_W + 1)'(NUM_BANKS));
        hit      = prot_pad[bank_i];
        deny_o   = vld_i && (hit || !in_range || all_prot_i);
        grant_o  = vld_i && !deny_o;
    end
endmodule

// File: rtl/fwp_ctrl.sv
module fwp_ctrl
    import fwp_pkg::*;
#(
    parameter int NUM_BANKS = 20,
    parameter int RO_BANKS  = 4,
    parameter int PS_BANKS  = 1,
    localparam int NUM_REGS = (NUM_BANKS + 7) / 8,
    localparam int ADDR_W   = $clog2(NUM_REGS + 1),
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                           clk,
    input  logic                           por_n,
    input  logic                           wrst_n,
    input  logic                           cfg_we,
    input  logic [ADDR_W-1:0]              cfg_addr,
    input  logic [NUM_REQ-1:0]             cfg_sel,
    input  logic [7:0]                     cfg_wdata,
    input  logic [NUM_REQ-1:0]             req_vld,
    input  logic [NUM_REQ-1:0][BANK_W-1:0] req_bank,
    output logic [NUM_REQ-1:0]             req_grant,
    output logic [NUM_REQ-1:0]             req_deny,
    output logic                           stat_ro,
    output logic                           stat_all,
    output logic                           lock_q
);
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(NUM_REGS);

    lock_state_e                         lk_state_q;
    lock_state_e                         lk_state_d;
    logic                                lock_wr;
    logic                                prot_wr_ok;
    logic [NUM_REQ-1:0][NUM_BANKS-1:0]   prot_sets;
    prot_stat_e                          stat;

    assign lock_wr = cfg_we && (cfg_addr == LOCK_ADDR);

    // Lock state register: only the power-on reset returns it to open.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lk_state_q <= LK_OPEN;
        end else begin
            lk_state_q <= lk_state_d;
        end
    end

    // Next state and outputs of the lock machine.
    always_comb begin
        lk_state_d = lk_state_q;
        lock_q     = 1'b0;
        prot_wr_ok = 1'b0;
        unique case (lk_state_q)
            LK_OPEN: begin
                prot_wr_ok = cfg_we && (cfg_addr < LOCK_ADDR);
                if (lock_wr && cfg_wdata[0]) begin
                    lk_state_d = LK_SEALED;
                end
            end
            LK_SEALED: begin
                lock_q = 1'b1;
            end
            default: lk_state_d = LK_OPEN;
        endcase
    end

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
        fwp_bank_regs #(
            .NUM_BANKS (NUM_BANKS),
            .ADDR_W    (ADDR_W)
        ) u_regs (
            .clk     (clk),
            .por_n   (por_n),
            .wrst_n  (wrst_n),
            .wr_en   (prot_wr_ok && cfg_sel[i]),
            .wr_addr (cfg_addr),
            .wr_data (cfg_wdata),
            .prot_o  (prot_sets[i])
        );

        fwp_gate #(
            .NUM_BANKS (NUM_BANKS),
            .BANK_W    (BANK_W)
        ) u_gate (
            .vld_i      (req_vld[i]),
            .bank_i     (req_bank[i]),
            .prot_i     (prot_sets[i]),
            .all_prot_i (stat_all),
            .grant_o    (req_grant[i]),
            .deny_o     (req_deny[i])
        );
    end

    fwp_run_status #(
        .NUM_BANKS (NUM_BANKS),
        .RO_BANKS  (RO_BANKS),
        .PS_BANKS  (PS_BANKS)
    ) u_stat (
        .prot_i (prot_sets[REQ_EC]),
        .stat_o (stat)
    );

    assign stat_ro  = (stat == ST_RO);
    assign stat_all = (stat == ST_ALL);
endmodule

// File: rtl/fwp_ctrl_chk.sv
module fwp_ctrl_chk #(
    parameter int NUM_BANKS = 20,
    parameter int ADDR_W    = 2,
    parameter int BANK_W    = 5
) (
    input logic                clk,
    input logic                por_n,
    input logic                wrst_n,
    input logic                cfg_we,
    input logic [ADDR_W-1:0]   cfg_addr,
    input logic [7:0]          cfg_wdata,
    input logic [2:0]          req_vld,
    input logic [2:0][BANK_W-1:0] req_bank,
    input logic [2:0]          req_grant,
    input logic [2:0]          req_deny,
    input logic                stat_ro,
    input logic                stat_all,
    input logic                lock_q
);
    localparam int NUM_REGS = (NUM_BANKS + 7) / 8;
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(NUM_REGS);

    AST_GRANT_DENY_SPLIT: assert property (@(posedge clk) disable iff (!por_n)
        ((req_grant | req_deny) == req_vld) && ((req_grant & req_deny) == 3'b000)); // R4
    AST_STAT_EXCL: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({stat_ro, stat_all})); // R6
    AST_ALL_DENIES: assert property (@(posedge clk) disable iff (!por_n)
        stat_all |-> (req_grant == 3'b000)); // R7
    AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_we && (cfg_addr == LOCK_ADDR) && cfg_wdata[0]) |=> lock_q); // R8
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        lock_q |=> lock_q); // R10
    AST_DENY_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (req_vld[0] && req_deny[0] && wrst_n) |=>
        ((req_vld[0] && (req_bank[0] == $past(req_bank[0]))) ? req_deny[0] : 1'b1)); // R3
    AST_LOCKED_NO_NEW: assert property (@(posedge clk) disable iff (!por_n)
        (lock_q && req_vld[1] && req_grant[1]) |=>
        ((req_vld[1] && (req_bank[1] == $past(req_bank[1]))) ? req_grant[1] : 1'b1)); // R9
endmodule

bind fwp_ctrl fwp_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .wrst_n    (wrst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .req_vld   (req_vld),
    .req_bank  (req_bank),
    .req_grant (req_grant),
    .req_deny  (req_deny),
    .stat_ro   (stat_ro),
    .stat_all  (stat_all),
    .lock_q    (lock_q)
);

// File: tb/fwp_ctrl_tb.sv
module fwp_ctrl_tb;
    localparam int NB     = 20;
    localparam int AW     = 2;
    localparam int BW     = 5;
    localparam logic [AW-1:0] LOCK_A = 2'd3;
    localparam logic [2:0] S_EC = 3'b001, S_HOST = 3'b010, S_DBG = 3'b100;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              wrst_n = 1'b1;
    logic              cfg_we = 1'b0;
    logic [AW-1:0]     cfg_addr = '0;
    logic [2:0]        cfg_sel = '0;
    logic [7:0]        cfg_wdata = '0;
    logic [2:0]        req_vld = '0;
    logic [2:0][BW-1:0] req_bank = '0;
    logic [2:0]        req_grant;
    logic [2:0]        req_deny;
    logic              stat_ro;
    logic              stat_all;
    logic              lock_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    fwp_ctrl u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .wrst_n    (wrst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .req_vld   (req_vld),
        .req_bank  (req_bank),
        .req_grant (req_grant),
        .req_deny  (req_deny),
        .stat_ro   (stat_ro),
        .stat_all  (stat_all),
        .lock_q    (lock_q)
    );

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [2:0] s, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    endtask

    // returns 1 for deny, 0 for grant, 2 for an illegal grant/deny pair
    task automatic probe(int who, int bank, output int res);
        req_vld = '0;
        req_vld[who] = 1'b1;
        req_bank[who] = BW'(bank);
        #1;
        res = (req_deny[who] && !req_grant[who]) ? 1 :
              (!req_deny[who] && req_grant[who]) ? 0 : 2;
        req_vld = '0;
        #1;
    endtask

    task automatic expect_deny(string tag, int who, int bank, int exp);
        int r;
        probe(who, bank, r);
        check(tag, r, exp);
    endtask

    task automatic warm_reset();
        @(negedge clk); wrst_n = 1'b0;
        @(negedge clk); wrst_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R10 reset lock_q", lock_q, 0);
        check("R6 reset stat_ro", stat_ro, 0);
        check("R6 reset stat_all", stat_all, 0);
        expect_deny("R4 reset EC bank0 granted", 0, 0, 0);
        #1;
        check("R4 idle no grant/deny", int'(req_grant | req_deny), 0);
    endtask

    task automatic t_map();
        wr(2'd1, S_EC, 8'h04);                      // bank 10 = reg1 bit2
        expect_deny("R1 EC bank10 denied", 0, 10, 1);
        expect_deny("R1 EC bank9 granted", 0, 9, 0);
        expect_deny("R1 EC bank11 granted", 0, 11, 0);
        expect_deny("R2 host bank10 untouched", 1, 10, 0);
        expect_deny("R2 dbg bank10 untouched", 2, 10, 0);
    endtask

    task automatic t_multi();
        wr(2'd0, S_HOST | S_DBG, 8'h01);
        expect_deny("R2 host bank0 denied", 1, 0, 1);
        expect_deny("R2 dbg bank0 denied", 2, 0, 1);
        expect_deny("R2 EC bank0 granted", 0, 0, 0);
    endtask

    task automatic t_sticky();
        wr(2'd1, S_EC, 8'h00);
        expect_deny("R3 zero write keeps bank10", 0, 10, 1);
        wr(2'd1, S_EC, 8'h08);
        expect_deny("R3 OR keeps bank10", 0, 10, 1);
        expect_deny("R3 OR adds bank11", 0, 11, 1);
    endtask

    task automatic t_range();
        expect_deny("R5 bank20 out of range", 0, 20, 1);
        expect_deny("R5 bank31 out of range", 1, 31, 1);
        expect_deny("R5 bank19 in range", 0, 19, 0);
    endtask

    task automatic t_status();
        wr(2'd0, S_EC, 8'h0F);                      // run = 4
        #1 check("R6 run4 stat_ro", stat_ro, 1);
        check("R6 run4 stat_all", stat_all, 0);
        wr(2'd0, S_EC, 8'h10);                      // run = 5
        #1 check("R6 run5 stat_ro", stat_ro, 1);
        wr(2'd0, S_EC, 8'h20);                      // run = 6
        #1 check("R6 run6 stat_ro", stat_ro, 0);
        check("R6 run6 stat_all", stat_all, 0);
    endtask

    task automatic t_warm();
        warm_reset();
        expect_deny("R10 warm clears EC bank10", 0, 10, 0);
        expect_deny("R10 warm clears host bank0", 1, 0, 0);
        #1 check("R10 warm stat_ro", stat_ro, 0);
    endtask

    task automatic t_all();
        wr(2'd0, S_EC, 8'hFF);
        wr(2'd1, S_EC, 8'hFF);
        #1 check("R6 run16 stat_all", stat_all, 0);
        wr(2'd2, S_EC, 8'h0F);
        #1 check("R6 run20 stat_all", stat_all, 1);
        check("R6 run20 stat_ro", stat_ro, 0);
        expect_deny("R7 host denied when all", 1, 3, 1);
        expect_deny("R7 dbg denied when all", 2, 19, 1);
    endtask

    task automatic t_lock();
        warm_reset();
        wr(LOCK_A, 3'b000, 8'h02);
        #1 check("R8 bit1 ignored", lock_q, 0);
        wr(LOCK_A, 3'b000, 8'h01);
        #1 check("R8 lock set", lock_q, 1);
        wr(2'd0, S_EC | S_HOST, 8'hFF);
        expect_deny("R9 locked EC write dropped", 0, 0, 0);
        expect_deny("R9 locked host write dropped", 1, 7, 0);
        #1 check("R9 locked stat_ro", stat_ro, 0);
        wr(LOCK_A, 3'b000, 8'h00);
        #1 check("R8 zero write keeps lock", lock_q, 1);
        warm_reset();
        #1 check("R10 warm keeps lock", lock_q, 1);
        @(negedge clk); por_n = 1'b0;
        #1 check("R10 por clears lock", lock_q, 0);
        @(negedge clk); por_n = 1'b1;
        wr(2'd0, S_EC, 8'h01);
        expect_deny("R9 writes work after por", 0, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_multi();
        t_sticky();
        t_range();
        t_status();
        t_warm();
        t_all();
        t_lock();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule